// File: doc/BRIEF.md
# CAN Controller Configuration Guard and Power-Mode Controller

This block wraps the protocol engine of a CAN controller. It sits between a simple CPU register bus and that engine. The bus has an address, write data, a write strobe and combinational read data. The block owns the configuration registers that the engine consumes. It lets software change them only while the controller is off-line. It reports the two error counters as read-only values, and it keeps track of the operating mode.

The modes are normal, sleep, soft reset and power down. Sleep and soft reset are chosen by two control bits. Power down is entered when an external stop input is high while one of those two modes is active. From the mode, the block produces:
- a register-access clock enable;
- a vector of engine clock enables;
- the transmit pin, which is held recessive in every reduced-power mode;
- a wakeup interrupt, raised by bus activity during sleep.

The bit-timing logic, acceptance filtering, message buffers and framing live elsewhere. They only read the registers and status held here.

Top module: `canModeGuard`

## Requirements
- R1: Address 13 reads the receive error count input and address 14 reads the transmit error count input. Bus writes to these addresses change nothing. Address 15 reads 0.
- R2: The configuration group occupies addresses 1 to 12 and resets to 0. While the soft-reset bit (bit 0 of the control register at address 0) is 1, a write to one of these addresses is stored and read back.
- R3: While the soft-reset bit is 0, writes to addresses 1 to 12 are ignored, and the stored values stay unchanged.
- R4: After reset the control register reads 0x01: soft reset set, everything else clear. Clearing bit 0 puts the block on-line.
- R5: The `mode` output is 2 (soft reset) when the soft-reset bit is 1. It is 1 (sleep) when the sleep-acknowledge bit (bit 2) is 1 and soft reset is 0. Otherwise it is 0 (normal). When `stopIn` is high in sleep or soft reset, `mode` is 3 (power down). `stopIn` has no effect in normal mode.
- R6: In normal mode `regClkEn` and every bit of `coreClkEn` are 1. In sleep and soft reset, only `regClkEn` is 1. In power down, all clock enables are 0.
- R7: `txOut` follows `engTx` in normal mode and is 1 in every other mode.
- R8: The sleep-request bit is bit 1. Sleep acknowledge (bit 2, read-only) is set at the first clock edge where sleep request is 1 and `busIdle` is 1. It is cleared at the edge after sleep request reads 0. While `busIdle` is 0, it is never set.
- R9: The wakeup flag is bit 4. It is set by a falling edge on `rxIn` while sleep acknowledge is 1 and soft reset is 0, and by no edge in normal mode. Writing 1 to bit 4 clears it; writing 0 leaves it as it is. A set in the same cycle as a clear wins.
- R10: `wakeIrq` is 1 exactly when the wakeup flag, the wakeup enable (bit 3) and sleep acknowledge are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register address |
| wrData | input | DATA_W | Write data |
| wrEn | input | 1 | Write strobe, one write per cycle |
| rdData | output | DATA_W | Read data for `addr`, combinational |
| rxErrCnt | input | DATA_W | Receive error count from the engine |
| txErrCnt | input | DATA_W | Transmit error count from the engine |
| busIdle | input | 1 | Engine reports the bus idle |
| rxIn | input | 1 | Receive line |
| engTx | input | 1 | Transmit bit from the engine |
| stopIn | input | 1 | Chip-level stop request |
| txOut | output | 1 | Transmit pin |
| regClkEn | output | 1 | Register-access clock enable |
| coreClkEn | output | NUM_CORE_CLK | Engine clock enables |
| mode | output | 2 | Current mode: 0 normal, 1 sleep, 2 soft reset, 3 power down |
| wakeIrq | output | 1 | Wakeup interrupt |

## Verification
The bench builds the block with its defaults: ADDR_W 4, DATA_W 8 and NUM_CORE_CLK 3. With these values every decoded address, including the unmapped one, can be reached through the address input. Three engine enables are enough to show that the clock gating moves all bits of the vector together, not just one. The 8-bit data path carries the whole control register, so each flag and mode bit is visible in a single read after every step of the sleep, wakeup and power-down sequences.

// File: rtl/canGuardPkg.sv
package canGuardPkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_SLEEP   = 2'd1,
    MODE_SOFTRST = 2'd2,
    MODE_PWRDN   = 2'd3
  } canMode_e;

  typedef struct packed {
    logic     cfgWrOk;
    canMode_e mode;
  } ctlStrobe_t;

  localparam int ADDR_CTL0  = 0;
  localparam int CFG_BASE   = 1;
  localparam int CFG_CNT    = 12;
  localparam int ADDR_RXERR = CFG_BASE + CFG_CNT;
  localparam int ADDR_TXERR = ADDR_RXERR + 1;

  localparam int BIT_SOFTRST  = 0;
  localparam int BIT_SLEEPREQ = 1;
  localparam int BIT_SLEEPACK = 2;
  localparam int BIT_WAKEIE   = 3;
  localparam int BIT_WAKEFLAG = 4;

endpackage

// File: rtl/canGuardCtrl.sv
module canGuardCtrl
  import canGuardPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              busIdle,
  input  logic              rxIn,
  input  logic              stopIn,
  output ctlStrobe_t        strobe,
  output logic [DATA_W-1:0] ctlView,
  output logic              softRst,
  output logic              sleepAck,
  output logic              wakeIe,
  output logic              wakeFlag,
  output logic              wakeIrq
);

  logic     sleepReq;
  logic     rxPrev;
  logic     ctlWr;
  logic     wakeEdge;
  canMode_e baseMode;

  assign ctlWr    = wrEn && (addr == ADDR_W'(ADDR_CTL0));
  assign wakeEdge = rxPrev && !rxIn && sleepAck && !softRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softRst  <= 1'b1;
      sleepReq <= 1'b0;
      wakeIe   <= 1'b0;
    end else if (ctlWr) begin
      softRst  <= wrData[BIT_SOFTRST];
      sleepReq <= wrData[BIT_SLEEPREQ];
      wakeIe   <= wrData[BIT_WAKEIE];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepAck <= 1'b0;
    end else if (!sleepReq) begin
      sleepAck <= 1'b0;
    end else if (busIdle) begin
      sleepAck <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeFlag <= 1'b0;
      rxPrev   <= 1'b1;
    end else begin
      rxPrev <= rxIn;
      if (wakeEdge) begin
        wakeFlag <= 1'b1;
      end else if (ctlWr && wrData[BIT_WAKEFLAG]) begin
        wakeFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    if (softRst) begin
      baseMode = MODE_SOFTRST;
    end else if (sleepAck) begin
      baseMode = MODE_SLEEP;
    end else begin
      baseMode = MODE_NORMAL;
    end
    strobe.mode    = (baseMode != MODE_NORMAL && stopIn) ? MODE_PWRDN : baseMode;
    strobe.cfgWrOk = softRst;
  end

  always_comb begin
    ctlView               = '0;
    ctlView[BIT_SOFTRST]  = softRst;
    ctlView[BIT_SLEEPREQ] = sleepReq;
    ctlView[BIT_SLEEPACK] = sleepAck;
    ctlView[BIT_WAKEIE]   = wakeIe;
    ctlView[BIT_WAKEFLAG] = wakeFlag;
  end

  assign wakeIrq = wakeFlag && wakeIe && sleepAck;

endmodule

// File: rtl/canGuardRegs.sv
module canGuardRegs
  import canGuardPkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int NUM_CORE_CLK = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wrData,
  input  logic                    wrEn,
  input  ctlStrobe_t              strobe,
  input  logic [DATA_W-1:0]       ctlView,
  input  logic [DATA_W-1:0]       rxErrCnt,
  input  logic [DATA_W-1:0]       txErrCnt,
  input  logic                    engTx,
  output logic [DATA_W-1:0]       rdData,
  output logic                    txOut,
  output logic                    regClkEn,
  output logic [NUM_CORE_CLK-1:0] coreClkEn
);

  logic [DATA_W-1:0] cfgReg [CFG_CNT];
  logic [CFG_CNT-1:0] cfgHit;

  for (genvar i = 0; i < CFG_CNT; i++) begin : gCfg
    assign cfgHit[i] = (addr == ADDR_W'(CFG_BASE + i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgReg[i] <= '0;
      end else if (wrEn && strobe.cfgWrOk && cfgHit[i]) begin
        cfgReg[i] <= wrData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(ADDR_CTL0)) begin
      rdData = ctlView;
    end else if (addr == ADDR_W'(ADDR_RXERR)) begin
      rdData = rxErrCnt;
    end else if (addr == ADDR_W'(ADDR_TXERR)) begin
      rdData = txErrCnt;
    end
    for (int k = 0; k < CFG_CNT; k++) begin
      if (cfgHit[k]) begin
        rdData = cfgReg[k];
      end
    end
  end

  always_comb begin
    regClkEn  = (strobe.mode != MODE_PWRDN);
    coreClkEn = (strobe.mode == MODE_NORMAL) ? '1 : '0;
    txOut     = (strobe.mode == MODE_NORMAL) ? engTx : 1'b1;
  end

endmodule

// File: rtl/canModeGuard.sv
module canModeGuard
  import canGuardPkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int NUM_CORE_CLK = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wrData,
  input  logic                    wrEn,
  output logic [DATA_W-1:0]       rdData,
  input  logic [DATA_W-1:0]       rxErrCnt,
  input  logic [DATA_W-1:0]       txErrCnt,
  input  logic                    busIdle,
  input  logic                    rxIn,
  input  logic                    engTx,
  input  logic                    stopIn,
  output logic                    txOut,
  output logic                    regClkEn,
  output logic [NUM_CORE_CLK-1:0] coreClkEn,
  output logic [1:0]              mode,
  output logic                    wakeIrq
);

  ctlStrobe_t        strobe;
  logic [DATA_W-1:0] ctlView;
  logic              softRst;
  logic              sleepAck;
  logic              wakeIe;
  logic              wakeFlag;

  canGuardCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .busIdle(busIdle), .rxIn(rxIn), .stopIn(stopIn), .strobe(strobe),
    .ctlView(ctlView), .softRst(softRst), .sleepAck(sleepAck),
    .wakeIe(wakeIe), .wakeFlag(wakeFlag), .wakeIrq(wakeIrq)
  );

  canGuardRegs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CORE_CLK(NUM_CORE_CLK)) uRegs (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .strobe(strobe), .ctlView(ctlView), .rxErrCnt(rxErrCnt),
    .txErrCnt(txErrCnt), .engTx(engTx), .rdData(rdData), .txOut(txOut),
    .regClkEn(regClkEn), .coreClkEn(coreClkEn)
  );

  assign mode = strobe.mode;

endmodule

// File: rtl/canModeGuardChk.sv
module canModeGuardChk #(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int NUM_CORE_CLK = 3
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [ADDR_W-1:0]       addr,
  input logic [DATA_W-1:0]       rdData,
  input logic [DATA_W-1:0]       rxErrCnt,
  input logic [DATA_W-1:0]       txErrCnt,
  input logic                    busIdle,
  input logic                    txOut,
  input logic                    regClkEn,
  input logic [NUM_CORE_CLK-1:0] coreClkEn,
  input logic [1:0]              mode,
  input logic                    wakeIrq,
  input logic                    softRst,
  input logic                    sleepAck
);

  AST_RXERR_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(13)) |-> (rdData == rxErrCnt)); // R1

  AST_TXERR_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(14)) |-> (rdData == txErrCnt)); // R1

  AST_SOFT_MODE: assert property (@(posedge clk) disable iff (!rstN)
    softRst |-> (mode == 2'd2 || mode == 2'd3)); // R5

  AST_PWRDN_NO_CLK: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3) |-> (!regClkEn && coreClkEn == '0)); // R6

  AST_LOWPWR_CORE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'd0) |-> (coreClkEn == '0)); // R6

  AST_TX_RECESSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'd0) |-> txOut); // R7

  AST_ACK_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepAck) |-> $past(busIdle)); // R8

  AST_IRQ_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !sleepAck |-> !wakeIrq); // R10

endmodule

bind canModeGuard canModeGuardChk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CORE_CLK(NUM_CORE_CLK)
) uChk (.*);

// File: tb/canModeGuard_test.sv
module canModeGuard_test;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int NCLK   = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic              wrEn = 1'b0;
  logic [DATA_W-1:0] rdData;
  logic [DATA_W-1:0] rxErrCnt = 8'h12;
  logic [DATA_W-1:0] txErrCnt = 8'h34;
  logic              busIdle = 1'b1;
  logic              rxIn = 1'b1;
  logic              engTx = 1'b0;
  logic              stopIn = 1'b0;
  logic              txOut;
  logic              regClkEn;
  logic [NCLK-1:0]   coreClkEn;
  logic [1:0]        mode;
  logic              wakeIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  canModeGuard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CORE_CLK(NCLK)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdData(rdData), .rxErrCnt(rxErrCnt), .txErrCnt(txErrCnt),
    .busIdle(busIdle), .rxIn(rxIn), .engTx(engTx), .stopIn(stopIn),
    .txOut(txOut), .regClkEn(regClkEn), .coreClkEn(coreClkEn),
    .mode(mode), .wakeIrq(wakeIrq)
  );

  // {control value, address, write data, expected read}
  localparam int NVEC = 9;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h01_02_A5_A5,  // R2 stored while off-line
    32'h00_02_3C_A5,  // R3 on-line write ignored
    32'h00_09_77_00,  // R3
    32'h01_09_77_77,  // R2
    32'h01_0C_81_81,  // R2 last group address
    32'h00_0C_FF_81,  // R3
    32'h01_0D_55_12,  // R1 rx counter read-only
    32'h00_0E_55_34,  // R1 tx counter read-only
    32'h01_0F_66_00   // R1 unmapped reads zero
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finishRun();
    end
  end

  initial begin
    logic [DATA_W-1:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state
    busRead(4'd0, rd);
    chk("R4 ctl reset", rd, 8'h01);
    chk("R5 reset mode", mode, 2'd2);
    chk("R6 reset regClkEn", regClkEn, 1'b1);
    chk("R6 reset coreClkEn", coreClkEn, 3'b000);
    chk("R7 reset txOut", txOut, 1'b1);
    busRead(4'd5, rd);
    chk("R2 group reset value", rd, 8'h00);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      busWrite(4'd0, VEC[i][31:24]);
      busWrite(VEC[i][19:16], VEC[i][15:8]);
      busRead(VEC[i][19:16], rd);
      chk($sformatf("R1/R2/R3 vector %0d", i), rd, VEC[i][7:0]);
    end

    // Normal mode
    busWrite(4'd0, 8'h00);
    #1;
    chk("R5 normal mode", mode, 2'd0);
    chk("R6 normal core", coreClkEn, 3'b111);
    chk("R6 normal reg", regClkEn, 1'b1);
    chk("R7 tx follows 0", txOut, 1'b0);
    engTx = 1'b1; #1;
    chk("R7 tx follows 1", txOut, 1'b1);
    engTx = 1'b0;

    // No wakeup in normal mode
    @(negedge clk); rxIn = 1'b0;
    repeat (2) @(negedge clk);
    busRead(4'd0, rd);
    chk("R9 no flag in normal", rd, 8'h00);
    rxIn = 1'b1;
    @(negedge clk);

    // Sleep handshake held off by busy bus
    busIdle = 1'b0;
    busWrite(4'd0, 8'h02);
    repeat (3) @(negedge clk);
    busRead(4'd0, rd);
    chk("R8 no ack while busy", rd, 8'h02);
    busIdle = 1'b1;
    @(negedge clk);
    busRead(4'd0, rd);
    chk("R8 ack after idle", rd, 8'h06);
    chk("R5 sleep mode", mode, 2'd1);
    chk("R6 sleep core", coreClkEn, 3'b000);
    chk("R6 sleep reg", regClkEn, 1'b1);
    chk("R7 sleep tx", txOut, 1'b1);

    // Wakeup with interrupt enabled
    busWrite(4'd0, 8'h0A);
    rxIn = 1'b0;
    @(negedge clk);
    #1;
    chk("R10 irq on wake", wakeIrq, 1'b1);
    busRead(4'd0, rd);
    chk("R9 flag set", rd, 8'h1E);
    rxIn = 1'b1;
    busWrite(4'd0, 8'h1A);
    busRead(4'd0, rd);
    chk("R9 flag cleared", rd, 8'h0E);
    chk("R10 irq cleared", wakeIrq, 1'b0);

    // Wakeup with interrupt masked
    busWrite(4'd0, 8'h02);
    rxIn = 1'b0;
    @(negedge clk);
    #1;
    chk("R10 masked irq", wakeIrq, 1'b0);
    busRead(4'd0, rd);
    chk("R9 masked flag", rd, 8'h16);
    rxIn = 1'b1;

    // Sleep request withdrawn: ack drops a cycle later
    busWrite(4'd0, 8'h08);
    busRead(4'd0, rd);
    chk("R8 ack held one edge", rd, 8'h1C);
    chk("R10 irq while ack", wakeIrq, 1'b1);
    @(negedge clk);
    busRead(4'd0, rd);
    chk("R8 ack dropped", rd, 8'h18);
    chk("R10 irq needs ack", wakeIrq, 1'b0);
    busWrite(4'd0, 8'h10);
    busRead(4'd0, rd);
    chk("R9 write one clears", rd, 8'h00);

    // Power down
    stopIn = 1'b1; #1;
    chk("R5 stop ignored in normal", mode, 2'd0);
    chk("R6 stop normal reg", regClkEn, 1'b1);
    busWrite(4'd0, 8'h01);
    #1;
    chk("R5 power down mode", mode, 2'd3);
    chk("R6 power down reg", regClkEn, 1'b0);
    chk("R6 power down core", coreClkEn, 3'b000);
    chk("R7 power down tx", txOut, 1'b1);
    stopIn = 1'b0; #1;
    chk("R5 leave power down", mode, 2'd2);
    chk("R6 reg back", regClkEn, 1'b1);

    done = 1'b1;
    finishRun();
  end

endmodule